// File: doc/BRIEF.md
# Window Watchdog with Sampled Trigger

This block watches a microcontroller through a single trigger line. It stays idle until a reset sequencer sends a one-cycle release pulse. It then runs an ignore window. After that it alternates between open windows, where the software must trigger, and closed windows, where it must not. The trigger line is synchronized and then sampled once per sample period. A valid trigger is a falling edge that has been filtered for glitches over four consecutive samples.

When no valid trigger arrives before an open window runs out, or when one completes inside a closed window, the block emits a one-cycle reset request and returns to idle. A timing-mode input picks a fast or slow sample period. Every window lasts the same number of samples in either mode. A disable input turns supervision off completely.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and `req_o` is low. The state encoding is 0 idle, 1 ignore, 2 open, 3 closed.
- R2: In idle, a high `release_i` moves the block to the ignore window on the next clock. In any other state, or while disabled, `release_i` has no effect.
- R3: Once released, the synchronized `wdi_i` is sampled every `SMP_FAST_CYC` clocks when `fast_i` is 1, and every `SMP_SLOW_CYC` clocks when `fast_i` is 0. The first sample is taken that many clocks after the edge that leaves idle. The ignore, open and closed windows are each `WIN_SMP` samples long.
- R4: A valid trigger is four consecutive samples reading 1, 1, 0, 0, oldest first. It completes on the second 0. Any other sequence, such as a single high sample between lows, is not a trigger.
- R5: During the ignore window the trigger line has no effect. After `WIN_SMP` samples the block enters the open window with an empty sample history.
- R6: A valid trigger completing in the open window moves the block to the closed window at that sample, with its window count restarted and its history emptied.
- R7: If the open window takes `WIN_SMP` samples without a valid trigger, `req_o` pulses and the block goes idle.
- R8: A valid trigger completing in the closed window pulses `req_o`, and the block goes idle.
- R9: When the closed window expires, the open window starts and the sample history is kept. A trigger whose first three samples fell in the closed window and whose last sample is the first open sample is valid (R6).
- R10: `req_o` is high for exactly one clock, in the same cycle `state_o` shows idle. The block then stays idle until the next release.
- R11: While `disable_i` is high, the block is held idle from the next clock and `req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| release_i | input | 1 | Release pulse from the reset sequencer |
| wdi_i | input | 1 | Asynchronous trigger line from the microcontroller |
| fast_i | input | 1 | Timing mode: 1 fast sample period, 0 slow |
| disable_i | input | 1 | Turns supervision off while high |
| req_o | output | 1 | One-cycle reset request |
| state_o | output | 2 | Current window: 0 idle, 1 ignore, 2 open, 3 closed |

## Verification
The bench sweeps square-wave trigger patterns with many periods and phase offsets in both timing modes, and checks every sample slot against an arithmetic window model. The aim is to catch a decoder that accepts fewer than four samples or a lone high glitch, which would enter the closed window on noise. It also catches a window counter that is off by one sample, which would request a reset one sample early or late. Directed runs cover the straddling trigger across the closed-to-open boundary: a design that clears its history there would time out instead of closing. Other directed runs cover a pretrigger inside the closed window, which a faulty design would accept. The remaining runs cover trigger activity in the ignore window, which a faulty design would count, and disable with release, which a faulty design would let start a window.

// File: rtl/win_wd_pkg.sv
package win_wd_pkg;
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_IGNORE = 2'd1,
        WD_OPEN   = 2'd2,
        WD_CLOSED = 2'd3
    } wd_state_e;
endpackage

// File: rtl/win_wd_sync.sv
module win_wd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/win_wd_ticker.sv
module win_wd_ticker #(
    parameter int SMP_FAST_CYC = 12500,
    parameter int SMP_SLOW_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic tick_o
);
    localparam int MAXP = (SMP_FAST_CYC > SMP_SLOW_CYC) ? SMP_FAST_CYC : SMP_SLOW_CYC;
    localparam int TW   = $clog2(MAXP + 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW-1:0] last;

    always_comb begin
        last   = fast_i ? TW'(SMP_FAST_CYC - 1) : TW'(SMP_SLOW_CYC - 1);
        tick_o = run_i && (cnt_q >= last);
        if (!run_i || cnt_q >= last) cnt_d = '0;
        else                         cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/win_wd_decoder.sv
module win_wd_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic level_i,
    input  logic clear_i,
    output logic valid_o
);
    logic [2:0] hist_d, hist_q;

    always_comb begin
        valid_o = tick_i && (hist_q == 3'b110) && !level_i;
        hist_d  = hist_q;
        if (clear_i)     hist_d = '0;
        else if (tick_i) hist_d = {hist_q[1:0], level_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import win_wd_pkg::*;
#(
    parameter int SMP_FAST_CYC = 12500,
    parameter int SMP_SLOW_CYC = 50000,
    parameter int WIN_SMP      = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       release_i,
    input  logic       wdi_i,
    input  logic       fast_i,
    input  logic       disable_i,
    output logic       req_o,
    output logic [1:0] state_o
);
    localparam int            WCW   = $clog2(WIN_SMP + 1);
    localparam logic [WCW-1:0] WLAST = WCW'(WIN_SMP - 1);

    typedef struct packed {
        wd_state_e      state;
        logic [WCW-1:0] wcnt;
        logic           req;
    } wd_regs_t;

    wd_regs_t r_d, r_q;
    logic     wdi_s, tick, valid, clear;

    win_wd_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(wdi_i), .sync_o(wdi_s)
    );

    win_wd_ticker #(.SMP_FAST_CYC(SMP_FAST_CYC), .SMP_SLOW_CYC(SMP_SLOW_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(r_q.state != WD_IDLE),
        .fast_i(fast_i), .tick_o(tick)
    );

    win_wd_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .level_i(wdi_s),
        .clear_i(clear), .valid_o(valid)
    );

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        if (disable_i) begin
            r_d.state = WD_IDLE;
            r_d.wcnt  = '0;
        end else begin
            unique case (r_q.state)
                WD_IDLE: begin
                    if (release_i) begin
                        r_d.state = WD_IGNORE;
                        r_d.wcnt  = '0;
                    end
                end
                WD_IGNORE: begin
                    if (tick) begin
                        if (r_q.wcnt == WLAST) begin
                            r_d.state = WD_OPEN;
                            r_d.wcnt  = '0;
                        end else begin
                            r_d.wcnt = r_q.wcnt + 1'b1;
                        end
                    end
                end
                WD_OPEN: begin
                    if (tick) begin
                        if (valid) begin
                            r_d.state = WD_CLOSED;
                            r_d.wcnt  = '0;
                        end else if (r_q.wcnt == WLAST) begin
                            r_d.state = WD_IDLE;
                            r_d.wcnt  = '0;
                            r_d.req   = 1'b1;
                        end else begin
                            r_d.wcnt = r_q.wcnt + 1'b1;
                        end
                    end
                end
                WD_CLOSED: begin
                    if (tick) begin
                        if (valid) begin
                            r_d.state = WD_IDLE;
                            r_d.wcnt  = '0;
                            r_d.req   = 1'b1;
                        end else if (r_q.wcnt == WLAST) begin
                            r_d.state = WD_OPEN;
                            r_d.wcnt  = '0;
                        end else begin
                            r_d.wcnt = r_q.wcnt + 1'b1;
                        end
                    end
                end
                default: r_d.state = WD_IDLE;
            endcase
        end
        clear = (r_d.state != r_q.state) &&
                !(r_q.state == WD_CLOSED && r_d.state == WD_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= WD_IDLE;
            r_q.wcnt  <= '0;
            r_q.req   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o   = r_q.req;
    assign state_o = r_q.state;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rel,
    input logic       dis,
    input logic       req,
    input logic [1:0] st
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req); // R10
    AST_REQ_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (st == 2'd0)); // R10
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (st == 2'd0 && !req)); // R11
    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd0 && !(rel && !dis)) |=> (st == 2'd0)); // R2
    AST_IGNORE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd1) |=> (!req && st != 2'd3)); // R5
    AST_OPEN_NO_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd2) |=> (st != 2'd1)); // R6
endmodule

bind win_watchdog win_watchdog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rel(release_i), .dis(disable_i),
    .req(req_o), .st(state_o)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
    localparam int PF = 4;
    localparam int PS = 7;
    localparam int W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rel = 1'b0, wdi = 1'b0, fast = 1'b1, dis = 1'b0;
    logic req;
    logic [1:0] st;

    int total = 0;
    int bad = 0;
    int cur_p = PF;

    logic [1:0] m_st;
    int         m_cnt;
    logic [2:0] m_hist;
    logic       m_req;

    always #10 clk = ~clk;

    win_watchdog #(.SMP_FAST_CYC(PF), .SMP_SLOW_CYC(PS), .WIN_SMP(W)) uut (
        .clk(clk), .rst_n(rst_n), .release_i(rel), .wdi_i(wdi),
        .fast_i(fast), .disable_i(dis), .req_o(req), .state_o(st)
    );

    task automatic check(input string tag, input logic [1:0] est, input logic ereq);
        total++;
        if (st !== est || req !== ereq) begin
            bad++;
            $display("FAIL %s: state=%0d req=%0d expected state=%0d req=%0d",
                     tag, st, req, est, ereq);
        end
    endtask

    // window model from the requirements: R3..R9
    task automatic m_step(input logic s);
        int  cn;
        logic v;
        m_req = 1'b0;
        if (m_st == 2'd0) return;
        cn = m_cnt + 1;
        v  = (m_hist == 3'b110) && !s;
        case (m_st)
            2'd1: begin
                if (cn == W) begin m_st = 2'd2; m_cnt = 0; m_hist = 3'b000; end
                else begin m_cnt = cn; m_hist = {m_hist[1:0], s}; end
            end
            2'd2: begin
                if (v) begin m_st = 2'd3; m_cnt = 0; m_hist = 3'b000; end
                else if (cn == W) begin m_st = 2'd0; m_cnt = 0; m_req = 1'b1; end
                else begin m_cnt = cn; m_hist = {m_hist[1:0], s}; end
            end
            default: begin
                if (v) begin m_st = 2'd0; m_cnt = 0; m_req = 1'b1; end
                else if (cn == W) begin m_st = 2'd2; m_cnt = 0; m_hist = {m_hist[1:0], s}; end
                else begin m_cnt = cn; m_hist = {m_hist[1:0], s}; end
            end
        endcase
    endtask

    task automatic do_release();
        @(negedge clk) rel = 1'b1;
        @(negedge clk) rel = 1'b0;
        m_st = 2'd1; m_cnt = 0; m_hist = 3'b000; m_req = 1'b0;
    endtask

    task automatic slot(input logic lvl, input string tag);
        wdi = lvl;
        repeat (cur_p) @(negedge clk);
        m_step(lvl);
        check(tag, m_st, m_req);
    endtask

    task automatic quiesce();
        @(negedge clk) dis = 1'b1;
        rel = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 disabled", 2'd0, 1'b0);
        rel = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 release ignored", 2'd0, 1'b0);
        dis = 1'b0;
        @(negedge clk);
        check("R2 idle after disable", 2'd0, 1'b0);
        m_st = 2'd0; m_req = 1'b0;
    endtask

    task automatic run_str(input logic md, input string pat, input string tag,
                           input logic [1:0] fst, input logic freq);
        fast  = md;
        cur_p = md ? PF : PS;
        wdi   = 1'b0;
        do_release();
        for (int i = 0; i < pat.len(); i++) slot(pat[i] == 8'h31, tag);
        check(tag, fst, freq);
        quiesce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 2'd0, 1'b0);
        repeat (5) @(negedge clk);
        check("R2 no release", 2'd0, 1'b0);

        // R5: trigger inside ignore window, then open times out (R7)
        run_str(1'b1, "110011111111", "R5 ignore then R7 timeout", 2'd0, 1'b1);
        // R6: clean trigger in open
        run_str(1'b1, "0000001100", "R6 open trigger", 2'd3, 1'b0);
        // R4: lone highs are not triggers -> timeout
        run_str(1'b1, "000000101010", "R4 glitch rejected", 2'd0, 1'b1);
        // R8: pretrigger inside closed
        run_str(1'b1, "00000011001100", "R8 early trigger", 2'd0, 1'b1);
        // R9: straddling trigger across closed->open boundary
        run_str(1'b1, "00000011000001100", "R9 straddle", 2'd3, 1'b0);
        // R3: slow mode, same sequence lengths
        run_str(1'b0, "0000001100", "R3 slow open trigger", 2'd3, 1'b0);
        run_str(1'b0, "000000000000", "R3 slow timeout", 2'd0, 1'b1);
        // R10: pulse is single and block stays idle without release
        run_str(1'b1, "0000000000000000", "R10 stays idle", 2'd0, 1'b0);

        // R3 R4 sweep over periodic trigger patterns and phases
        for (int md = 0; md < 2; md++) begin
            for (int pi = 0; pi < 7; pi++) begin
                int per;
                per = (pi == 0) ? 4 : (pi == 1) ? 5 : (pi == 2) ? 6 :
                      (pi == 3) ? 7 : (pi == 4) ? 8 : (pi == 5) ? 10 : 13;
                for (int off = 0; off < per; off++) begin
                    fast  = md[0];
                    cur_p = md[0] ? PF : PS;
                    wdi   = 1'b0;
                    do_release();
                    for (int k = 0; k < 3 * W + 12; k++)
                        slot(((k + off) % per) < ((per + 1) / 2), "R3 R4 sweep");
                    quiesce();
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule